// File: doc/BRIEF.md
# Load Queue with Replay Tracking

This block is the load half of a memory ordering unit. Loads get a slot at the tail of a circular queue in program order. Each slot holds the load's 16-bit sequence number. A load leaves the queue from the head when the commit stage reports that everything up to a given sequence number has retired. One slot always stays empty so that the pointers can tell a full queue from an empty one.

When a load executes, the block sorts the request into one of four classes, in this priority:
- an uncacheable load issued too early,
- a load that only partly overlaps an older store that has not yet written back,
- a load refused by the memory port,
- a normal issue.

Each class produces a one-cycle response. For the partial-overlap case and the port-refusal case, the block keeps a record of the oldest offending load only. The pipeline uses these records to decide when to replay.

A squash removes every entry younger than a given sequence number. The entries come off the tail one per cycle. The control state machine has two states:
- `LQ_RUN`: normal operation. Allocate, execute and commit are served in this state.
- `LQ_SQUASH`: the tail is walked back.

A squash request moves `LQ_RUN` to `LQ_SQUASH` (transition *squash-start*). The block stays in `LQ_SQUASH` while the entry just below the tail is younger than the squash point (transition *squash-step*). It returns to `LQ_RUN` on the first cycle where that entry is not younger, or the queue is empty (transition *squash-done*).

Top module: `ldq_replay`

## Requirements
- R1: After reset the following all read 0: `count`, `full`, `busy`, `stall_active`, `blk_active`, `blk_handled` and every `resp_*` output. `alloc_idx` also reads 0.
- R2: `alloc_idx` always shows the tail slot index. An accepted allocate writes `alloc_seq` there, and the tail then advances by one modulo SLOTS. `full` is 1 exactly when `count` equals SLOTS-1. An allocate while `full` (or while `busy`) is ignored.
- R3: While `commit_valid` is high, `count` is nonzero and the head entry's sequence number is ≤ `commit_seq` (unsigned), one entry is released from the head each cycle.
- R4: `free_entries` equals the smaller of (SLOTS-1-`count`) and `store_free`.
- R5: An executed load with `exec_uncached`=1 is early when its index differs from the head index or `exec_at_commit`=0. An early load gives `resp_fault`=1 and `resp_resched`=1 and `resp_issue`=0, and it has priority over every other condition.
- R6: A load with `exec_partial`=1 (and not early) gives `resp_resched`=1. The stall record is written only if no stall is active, or if this load's sequence number is smaller than that of the recorded load. A write sets `stall_store_seq`=`exec_store_seq` and `stall_load_idx`=`exec_idx`.
- R7: A load with `exec_port_busy`=1 (and not early and not partial) gives a response with all three flags 0. It then sets `blk_active`, clears `blk_handled` and records its sequence number in `blk_seq`, unless an active record already holds a smaller sequence number. In that case nothing changes.
- R8: The acknowledge inputs act on the blocked record: `blk_clear` clears `blk_active`, and `blk_handled_set` sets `blk_handled`.
- R9: A squash (`squash_valid` while not `busy`) raises `busy` on the next cycle. The tail then moves back one entry per cycle while the entry below it has a sequence number > `squash_seq`. The walk spends k+1 cycles in `busy` for k removed entries. Allocate, execute and commit are ignored in the squash request cycle and while `busy`.
- R10: A squash clears the stall record and the blocked record if the recorded load's sequence number is > `squash_seq`. Otherwise it leaves them unchanged.
- R11: `stall_clear` clears `stall_active` (a stall write in the same cycle takes priority).
- R12: A load with none of the three conditions gives `resp_valid`=1 and `resp_issue`=1 one cycle after the execute request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated load |
| alloc_idx | output | IDX_W | Current tail slot index |
| exec_valid | input | 1 | Execute request |
| exec_idx | input | IDX_W | Slot of the executing load |
| exec_uncached | input | 1 | Load targets uncacheable memory |
| exec_at_commit | input | 1 | Load has reached the commit point |
| exec_partial | input | 1 | Store search found a partial overlap with an unwritten store |
| exec_store_seq | input | SEQ_W | Sequence number of that store |
| exec_port_busy | input | 1 | Memory port refused the access |
| resp_valid | output | 1 | Response to last cycle's execute request |
| resp_issue | output | 1 | Load was sent to memory |
| resp_resched | output | 1 | Load must be rescheduled |
| resp_fault | output | 1 | Machine-check style fault for an early uncacheable load |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest retired sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| stall_clear | input | 1 | Clears the stall record |
| blk_clear | input | 1 | Clears the blocked flag |
| blk_handled_set | input | 1 | Marks the blocked load as handled |
| store_free | input | CNT_W | Free store slots reported by the store side |
| full | output | 1 | Queue full |
| count | output | CNT_W | Occupied slots |
| free_entries | output | CNT_W | Minimum of free load and store slots |
| busy | output | 1 | Squash walk in progress |
| stall_active | output | 1 | A partial-overlap stall is recorded |
| stall_store_seq | output | SEQ_W | Blocking store of the recorded stall |
| stall_load_idx | output | IDX_W | Slot of the recorded stalling load |
| blk_active | output | 1 | A port-refused load is recorded |
| blk_handled | output | 1 | The blocked load has been handled |
| blk_seq | output | SEQ_W | Sequence number of the recorded blocked load |

## Verification
The hardest situation to reach is one where both replay records hold a load that a squash then removes, after each record has already been overwritten once by an older load. The stimulus first fills the queue. It then executes partial-overlap and port-refused loads in a younger, older, younger-again order. This proves that each record moves only toward older loads. It then squashes just behind the oldest entry, so both recorded loads fall inside the removed range.

A second squash is placed so that the stalling load survives it. The bench counts the `busy` cycles of each squash walk against the expected k+1.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
    typedef enum logic {
        LQ_RUN    = 1'b0,
        LQ_SQUASH = 1'b1
    } lq_state_e;

    typedef enum logic [1:0] {
        EX_ISSUE     = 2'd0,
        EX_UNC_EARLY = 2'd1,
        EX_PARTIAL   = 2'd2,
        EX_PORT_BUSY = 2'd3
    } ex_class_e;
endpackage

// File: rtl/ldq_seq_store.sv
module ldq_seq_store #(
    parameter int SLOTS = 16,
    parameter int SEQ_W = 16,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    input  logic [IDX_W-1:0] rd_c_idx,
    output logic [SEQ_W-1:0] rd_a_seq,
    output logic [SEQ_W-1:0] rd_b_seq,
    output logic [SEQ_W-1:0] rd_c_seq
);
    logic [SEQ_W-1:0] mem [SLOTS];

    function automatic logic [SEQ_W-1:0] pick(input logic [IDX_W-1:0] idx);
        logic [SEQ_W-1:0] v;
        v = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (idx == IDX_W'(i)) v = mem[i];
        end
        return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (wr_idx == IDX_W'(i)) mem[i] <= wr_seq;
            end
        end
    end

    always_comb begin
        rd_a_seq = pick(rd_a_idx);
        rd_b_seq = pick(rd_b_idx);
        rd_c_seq = pick(rd_c_idx);
    end
endmodule

// File: rtl/ldq_ring_ctrl.sv
module ldq_ring_ctrl
    import ldq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int SEQ_W = 16,
    parameter int IDX_W = $clog2(SLOTS),
    parameter int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_go,
    input  logic             commit_go,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             squash_go,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic [SEQ_W-1:0] tail_prev_seq,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [IDX_W-1:0] tail_prev,
    output logic [CNT_W-1:0] count,
    output logic             busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    lq_state_e        state_q, state_d;
    logic [IDX_W-1:0] head_d, tail_d;
    logic [CNT_W-1:0] count_d;
    logic [SEQ_W-1:0] cut_q, cut_d;
    logic             do_rel;

    function automatic logic [IDX_W-1:0] step_up(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + 1'b1;
    endfunction

    assign tail_prev = (tail == '0) ? LAST_IDX : tail - 1'b1;
    assign busy      = (state_q == LQ_SQUASH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LQ_RUN;
            head    <= '0;
            tail    <= '0;
            count   <= '0;
            cut_q   <= '0;
        end else begin
            state_q <= state_d;
            head    <= head_d;
            tail    <= tail_d;
            count   <= count_d;
            cut_q   <= cut_d;
        end
    end

    always_comb begin
        state_d = state_q;
        head_d  = head;
        tail_d  = tail;
        count_d = count;
        cut_d   = cut_q;
        do_rel  = 1'b0;
        unique case (state_q)
            LQ_RUN: begin
                if (squash_go) begin
                    state_d = LQ_SQUASH;
                    cut_d   = squash_seq;
                end else begin
                    do_rel = commit_go && (count != '0) && (head_seq <= commit_seq);
                    if (alloc_go) tail_d = step_up(tail);
                    if (do_rel)   head_d = step_up(head);
                    unique case ({alloc_go, do_rel})
                        2'b10:   count_d = count + 1'b1;
                        2'b01:   count_d = count - 1'b1;
                        default: count_d = count;
                    endcase
                end
            end
            LQ_SQUASH: begin
                if ((count != '0) && (tail_prev_seq > cut_q)) begin
                    tail_d  = tail_prev;
                    count_d = count - 1'b1;
                end else begin
                    state_d = LQ_RUN;
                end
            end
            default: state_d = LQ_RUN;
        endcase
    end
endmodule

// File: rtl/ldq_replay_track.sv
module ldq_replay_track
    import ldq_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_go,
    input  logic [IDX_W-1:0] exec_idx,
    input  logic [SEQ_W-1:0] exec_seq,
    input  logic             exec_uncached,
    input  logic             exec_at_commit,
    input  logic             exec_partial,
    input  logic [SEQ_W-1:0] exec_store_seq,
    input  logic             exec_port_busy,
    input  logic [IDX_W-1:0] head,
    input  logic             squash_go,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             stall_clear,
    input  logic             blk_clear,
    input  logic             blk_handled_set,
    output logic             resp_valid,
    output logic             resp_issue,
    output logic             resp_resched,
    output logic             resp_fault,
    output logic             stall_active,
    output logic [SEQ_W-1:0] stall_store_seq,
    output logic [IDX_W-1:0] stall_load_idx,
    output logic             blk_active,
    output logic             blk_handled,
    output logic [SEQ_W-1:0] blk_seq
);
    ex_class_e        ex_class;
    logic [SEQ_W-1:0] stall_load_seq;
    logic             stall_take, blk_take, stall_cut, blk_cut;

    always_comb begin
        if (exec_uncached && ((exec_idx != head) || !exec_at_commit)) ex_class = EX_UNC_EARLY;
        else if (exec_partial)                                          ex_class = EX_PARTIAL;
        else if (exec_port_busy)                                        ex_class = EX_PORT_BUSY;
        else                                                            ex_class = EX_ISSUE;
    end

    assign stall_take = exec_go && (ex_class == EX_PARTIAL) &&
                        (!stall_active || (exec_seq < stall_load_seq));
    assign blk_take   = exec_go && (ex_class == EX_PORT_BUSY) &&
                        !(blk_active && (blk_seq < exec_seq));
    assign stall_cut  = squash_go && stall_active && (stall_load_seq > squash_seq);
    assign blk_cut    = squash_go && blk_active && (blk_seq > squash_seq);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_issue   <= 1'b0;
            resp_resched <= 1'b0;
            resp_fault   <= 1'b0;
        end else begin
            resp_valid   <= exec_go;
            resp_issue   <= 1'b0;
            resp_resched <= 1'b0;
            resp_fault   <= 1'b0;
            if (exec_go) begin
                unique case (ex_class)
                    EX_UNC_EARLY: begin
                        resp_resched <= 1'b1;
                        resp_fault   <= 1'b1;
                    end
                    EX_PARTIAL:   resp_resched <= 1'b1;
                    EX_PORT_BUSY: resp_issue   <= 1'b0;
                    EX_ISSUE:     resp_issue   <= 1'b1;
                    default:      resp_issue   <= 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_active    <= 1'b0;
            stall_store_seq <= '0;
            stall_load_idx  <= '0;
            stall_load_seq  <= '0;
        end else if (stall_take) begin
            stall_active    <= 1'b1;
            stall_store_seq <= exec_store_seq;
            stall_load_idx  <= exec_idx;
            stall_load_seq  <= exec_seq;
        end else if (stall_clear || stall_cut) begin
            stall_active    <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_active  <= 1'b0;
            blk_handled <= 1'b0;
            blk_seq     <= '0;
        end else if (blk_take) begin
            blk_active  <= 1'b1;
            blk_handled <= 1'b0;
            blk_seq     <= exec_seq;
        end else begin
            if (blk_clear || blk_cut) blk_active  <= 1'b0;
            if (blk_handled_set)      blk_handled <= 1'b1;
        end
    end
endmodule

// File: rtl/ldq_replay.sv
module ldq_replay
    import ldq_pkg::*;
#(
    parameter  int SLOTS = 16,
    parameter  int SEQ_W = 16,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [SEQ_W-1:0] alloc_seq,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             exec_valid,
    input  logic [IDX_W-1:0] exec_idx,
    input  logic             exec_uncached,
    input  logic             exec_at_commit,
    input  logic             exec_partial,
    input  logic [SEQ_W-1:0] exec_store_seq,
    input  logic             exec_port_busy,
    output logic             resp_valid,
    output logic             resp_issue,
    output logic             resp_resched,
    output logic             resp_fault,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             stall_clear,
    input  logic             blk_clear,
    input  logic             blk_handled_set,
    input  logic [CNT_W-1:0] store_free,
    output logic             full,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] free_entries,
    output logic             busy,
    output logic             stall_active,
    output logic [SEQ_W-1:0] stall_store_seq,
    output logic [IDX_W-1:0] stall_load_idx,
    output logic             blk_active,
    output logic             blk_handled,
    output logic [SEQ_W-1:0] blk_seq
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(SLOTS - 1);

    logic [IDX_W-1:0] head, tail, tail_prev;
    logic [SEQ_W-1:0] head_seq, tail_prev_seq, exec_seq;
    logic             alloc_go, exec_go, commit_go, squash_go, idle;
    logic [CNT_W-1:0] load_free;

    assign idle      = !busy && !squash_valid;
    assign full      = (count >= CAP);
    assign alloc_go  = alloc_valid && !full && idle;
    assign exec_go   = exec_valid && idle;
    assign commit_go = commit_valid && idle;
    assign squash_go = squash_valid && !busy;
    assign alloc_idx = tail;

    assign load_free    = CAP - count;
    assign free_entries = (store_free < load_free) ? store_free : load_free;

    ldq_seq_store #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(alloc_go), .wr_idx(tail), .wr_seq(alloc_seq),
        .rd_a_idx(head), .rd_b_idx(tail_prev), .rd_c_idx(exec_idx),
        .rd_a_seq(head_seq), .rd_b_seq(tail_prev_seq), .rd_c_seq(exec_seq)
    );

    ldq_ring_ctrl #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) ring_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_go(alloc_go), .commit_go(commit_go), .commit_seq(commit_seq),
        .squash_go(squash_go), .squash_seq(squash_seq),
        .head_seq(head_seq), .tail_prev_seq(tail_prev_seq),
        .head(head), .tail(tail), .tail_prev(tail_prev),
        .count(count), .busy(busy)
    );

    ldq_replay_track #(.SEQ_W(SEQ_W), .IDX_W(IDX_W)) track_i (
        .clk(clk), .rst_n(rst_n),
        .exec_go(exec_go), .exec_idx(exec_idx), .exec_seq(exec_seq),
        .exec_uncached(exec_uncached), .exec_at_commit(exec_at_commit),
        .exec_partial(exec_partial), .exec_store_seq(exec_store_seq),
        .exec_port_busy(exec_port_busy), .head(head),
        .squash_go(squash_go), .squash_seq(squash_seq),
        .stall_clear(stall_clear), .blk_clear(blk_clear),
        .blk_handled_set(blk_handled_set),
        .resp_valid(resp_valid), .resp_issue(resp_issue),
        .resp_resched(resp_resched), .resp_fault(resp_fault),
        .stall_active(stall_active), .stall_store_seq(stall_store_seq),
        .stall_load_idx(stall_load_idx), .blk_active(blk_active),
        .blk_handled(blk_handled), .blk_seq(blk_seq)
    );
endmodule

// File: rtl/ldq_replay_chk.sv
module ldq_replay_chk #(
    parameter int SLOTS = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             full,
    input logic             busy,
    input logic             resp_valid,
    input logic             resp_issue,
    input logic             resp_resched,
    input logic             resp_fault,
    input logic             blk_active,
    input logic             blk_handled
);
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(SLOTS - 1)); // R2
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> count <= $past(count)); // R2
    AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ({1'b0, $past(count)} <= ({1'b0, count} + (CNT_W+1)'(1)))); // R3
    AST_FAULT_RESCHED: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_resched && !resp_issue)); // R5
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_issue, resp_resched})); // R6
    AST_BLK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_active) |-> !blk_handled); // R7
    AST_SQUASH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> count <= $past(count)); // R9
    AST_RESP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_issue || resp_resched) |-> resp_valid); // R12
endmodule

bind ldq_replay ldq_replay_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .count(count), .full(full), .busy(busy),
    .resp_valid(resp_valid), .resp_issue(resp_issue),
    .resp_resched(resp_resched), .resp_fault(resp_fault),
    .blk_active(blk_active), .blk_handled(blk_handled)
);

// File: tb/ldq_replay_tb.sv
`timescale 1ns/1ps
module ldq_replay_tb_top;
    localparam int SLOTS = 5;
    localparam int SEQ_W = 16;
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS);
    localparam int CAP   = SLOTS - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, exec_valid = 0, exec_uncached = 0, exec_at_commit = 0;
    logic exec_partial = 0, exec_port_busy = 0, commit_valid = 0, squash_valid = 0;
    logic stall_clear = 0, blk_clear = 0, blk_handled_set = 0;
    logic [SEQ_W-1:0] alloc_seq = '0, exec_store_seq = '0, commit_seq = '0, squash_seq = '0;
    logic [IDX_W-1:0] exec_idx = '0;
    logic [CNT_W-1:0] store_free = CNT_W'(CAP);
    logic [IDX_W-1:0] alloc_idx, stall_load_idx;
    logic resp_valid, resp_issue, resp_resched, resp_fault, full, busy;
    logic stall_active, blk_active, blk_handled;
    logic [CNT_W-1:0] count, free_entries;
    logic [SEQ_W-1:0] stall_store_seq, blk_seq;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ldq_replay #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic alloc(input int seq);
        alloc_valid = 1; alloc_seq = SEQ_W'(seq);
        tick();
        alloc_valid = 0;
    endtask

    task automatic exec(input int idx, input bit unc, input bit atc, input bit par,
                        input int sseq, input bit pb);
        exec_valid = 1; exec_idx = IDX_W'(idx); exec_uncached = unc; exec_at_commit = atc;
        exec_partial = par; exec_store_seq = SEQ_W'(sseq); exec_port_busy = pb;
        tick();
        exec_valid = 0; exec_uncached = 0; exec_at_commit = 0; exec_partial = 0; exec_port_busy = 0;
    endtask

    task automatic resp(input string req, input int iss, input int rs, input int flt);
        chk({req, " resp_valid"}, int'(resp_valid), 1);
        chk({req, " resp_issue"}, int'(resp_issue), iss);
        chk({req, " resp_resched"}, int'(resp_resched), rs);
        chk({req, " resp_fault"}, int'(resp_fault), flt);
    endtask

    task automatic free_sweep(input int cnt);
        for (int sf = 0; sf < (1 << CNT_W); sf++) begin
            store_free = CNT_W'(sf);
            #0.1;
            chk("R4 free_entries", int'(free_entries), ((CAP - cnt) < sf) ? (CAP - cnt) : sf);
        end
        store_free = CNT_W'(CAP);
    endtask

    task automatic squash(input int seq, input int exp_cycles);
        int n;
        squash_valid = 1; squash_seq = SEQ_W'(seq);
        tick();
        squash_valid = 0;
        n = 0;
        while (busy && n < 20) begin
            tick();
            n++;
        end
        chk("R9 squash busy cycles", n, exp_cycles);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 stall", int'(stall_active), 0);
        chk("R1 blk", int'(blk_active), 0);
        chk("R1 handled", int'(blk_handled), 0);
        chk("R1 resp", int'({resp_valid, resp_issue, resp_resched, resp_fault}), 0);
        chk("R1 alloc_idx", int'(alloc_idx), 0);
        free_sweep(0);

        // R2 fill: seqs 10..13 into slots 0..3
        for (int i = 0; i < CAP; i++) begin
            chk("R2 alloc_idx", int'(alloc_idx), i);
            alloc(10 + i);
            chk("R2 count", int'(count), i + 1);
            chk("R2 full", int'(full), (i + 1 == CAP) ? 1 : 0);
        end
        alloc(14);
        chk("R2 alloc when full ignored", int'(count), CAP);
        chk("R2 tail held when full", int'(alloc_idx), CAP);
        free_sweep(CAP);

        // R5 uncacheable: not head, head without commit, head with commit
        exec(2, 1, 1, 0, 0, 0); resp("R5 not head", 0, 1, 1);
        exec(0, 1, 0, 0, 0, 0); resp("R5 head no commit", 0, 1, 1);
        exec(0, 1, 1, 0, 0, 0); resp("R5 head at commit", 1, 0, 0);
        exec(1, 1, 0, 1, 0, 1); resp("R5 priority over partial", 0, 1, 1);
        chk("R5 no stall on early", int'(stall_active), 0);
        // R12 plain issue
        exec(1, 0, 0, 0, 0, 0); resp("R12 issue", 1, 0, 0);
        tick();
        chk("R12 resp one cycle", int'(resp_valid), 0);

        // R6 partial: younger (13@3), older (11@1), younger again (12@2)
        exec(3, 0, 0, 1, 7, 0); resp("R6 partial", 0, 1, 0);
        chk("R6 stall set", int'(stall_active), 1);
        chk("R6 store seq", int'(stall_store_seq), 7);
        chk("R6 load idx", int'(stall_load_idx), 3);
        exec(1, 0, 0, 1, 5, 0);
        chk("R6 older replaces seq", int'(stall_store_seq), 5);
        chk("R6 older replaces idx", int'(stall_load_idx), 1);
        exec(2, 0, 0, 1, 6, 1); resp("R6 younger partial", 0, 1, 0);
        chk("R6 younger keeps seq", int'(stall_store_seq), 5);
        chk("R6 younger keeps idx", int'(stall_load_idx), 1);
        chk("R7 partial beats port busy", int'(blk_active), 0);

        // R7/R8 port refusal
        exec(2, 0, 0, 0, 0, 1); resp("R7 port busy", 0, 0, 0);
        chk("R7 blk set", int'(blk_active), 1);
        chk("R7 blk seq", int'(blk_seq), 12);
        chk("R7 handled cleared", int'(blk_handled), 0);
        blk_handled_set = 1; tick(); blk_handled_set = 0;
        chk("R8 handled set", int'(blk_handled), 1);
        exec(3, 0, 0, 0, 0, 1);
        chk("R7 younger keeps seq", int'(blk_seq), 12);
        chk("R7 younger keeps handled", int'(blk_handled), 1);
        exec(1, 0, 0, 0, 0, 1);
        chk("R7 older replaces seq", int'(blk_seq), 11);
        chk("R7 older clears handled", int'(blk_handled), 0);

        // R9/R10 squash behind the oldest: removes 11,12,13
        squash(10, 4);
        chk("R9 count after squash", int'(count), 1);
        chk("R9 tail after squash", int'(alloc_idx), 1);
        chk("R10 stall cleared", int'(stall_active), 0);
        chk("R10 blk cleared", int'(blk_active), 0);

        // R8 blk_clear
        exec(0, 0, 0, 0, 0, 1);
        chk("R7 blk on head", int'(blk_seq), 10);
        blk_clear = 1; tick(); blk_clear = 0;
        chk("R8 blk cleared", int'(blk_active), 0);

        // R3 commit: slots hold 10@0,20@1,21@2,22@3
        alloc(20); alloc(21); alloc(22);
        commit_valid = 1; commit_seq = 16'd20;
        repeat (4) tick();
        commit_valid = 0;
        chk("R3 partial commit", int'(count), 2);
        chk("R2 wrap idx 4", int'(alloc_idx), 4);
        alloc(23);
        chk("R2 wrap idx 0", int'(alloc_idx), 0);
        alloc(24);
        chk("R2 wrap full", int'(full), 1);
        chk("R2 tail after wrap", int'(alloc_idx), 1);
        commit_valid = 1; commit_seq = 16'd30;
        tick();
        chk("R3 one per cycle", int'(count), 3);
        repeat (4) tick();
        commit_valid = 0;
        chk("R3 drain", int'(count), 0);
        commit_valid = 1; tick(); commit_valid = 0;
        chk("R3 empty commit", int'(count), 0);

        // R10/R11 squash that keeps the stalling load: 40@1,41@2,42@3
        alloc(40); alloc(41); alloc(42);
        free_sweep(3);
        exec(1, 0, 0, 1, 9, 0);
        chk("R6 stall on 40", int'(stall_active), 1);
        squash(41, 2);
        chk("R9 count keep", int'(count), 2);
        chk("R10 stall kept", int'(stall_active), 1);
        chk("R10 stall idx kept", int'(stall_load_idx), 1);
        stall_clear = 1; tick(); stall_clear = 0;
        chk("R11 stall cleared", int'(stall_active), 0);

        // R9 requests ignored while the walk runs
        alloc(43);
        squash_valid = 1; squash_seq = 16'd40; alloc_valid = 1; alloc_seq = 16'd99;
        tick();
        squash_valid = 0;
        chk("R9 busy", int'(busy), 1);
        while (busy) tick();
        alloc_valid = 0;
        chk("R9 alloc ignored while busy", int'(count), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule